// File: doc/BRIEF.md
# SMBus Bus Timeout Monitor

This block watches the clock and data lines of a two-wire SMBus-style bus and reports two conditions to the surrounding controller. The first is a clock line held low for too long, measured in system clock cycles against a programmable limit. A typical limit is the cycle count that matches 25 ms of continuous low clock. The second is an idle bus: both lines have stayed high for more than ten periods of a slower clock-source tick.

The low-timeout result is a sticky flag, which a one-cycle clear pulse removes. The bus-free result is a level that follows the lines. The line levels arrive already synchronized to the system clock. Any recovery action after a timeout, such as resetting the bus interface, belongs to logic outside this block. Each detector has its own enable. A disabled detector holds its counter at zero and forces its output inactive.

Top module: `smbus_timeout_mon`

## Requirements
- R1: While the clock line is high, the low-time counter is reloaded to zero at every system clock edge. A low interval that is broken by even one high sample never raises the flag unless a later unbroken interval reaches the limit.
- R2: With the low-timeout enable set and a limit L of at least 1, the flag rises in the cycle after the L-th consecutive clock edge at which the clock line is sampled low.
- R3: The flag stays set until a clear pulse is sampled high at a clock edge, and it drops in the next cycle. If a clear arrives at the same edge that the limit is reached, the flag sets.
- R4: After the limit is reached, the counter saturates. A clear applied while the clock line is still low keeps the flag low until a fresh low interval, started after a high sample, again reaches the full limit.
- R5: A limit of zero never raises the flag.
- R6: With the free-timeout enable set, the bus-free output rises in the cycle after the 11th clock-source tick that is sampled while both lines are high, counting only ticks since both lines last went high.
- R7: Whenever either line is low, the bus-free output is low in that same cycle, and the tick count restarts from zero.
- R8: While the low-timeout enable is clear, the flag output is low in that same cycle and the counter is held at zero. After re-enabling, a full new interval is needed.
- R9: While the free-timeout enable is clear, the bus-free output is low and the tick count is held at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Synchronized clock line level |
| sda_in | input | 1 | Synchronized data line level |
| src_tick | input | 1 | One-cycle pulse per clock-source period |
| low_tmo_en | input | 1 | Enable for clock-low timeout detection |
| free_tmo_en | input | 1 | Enable for bus-free detection |
| low_limit | input | LIMIT_W | Low-timeout limit in system clocks (0 disables) |
| low_tmo_clr | input | 1 | One-cycle clear of the low-timeout flag |
| low_tmo_flag | output | 1 | Sticky clock-low timeout flag |
| bus_free | output | 1 | Bus idle indication |

## Verification
The bench builds the block with an 8-bit limit width and the default free-detection count of ten ticks. This lets limits of 0, 1, 6 and the all-ones value 255 be exercised in a few hundred cycles, instead of the millions of cycles a real 25 ms limit would need. With these limits the bench reaches the exact rising cycle of the flag, the saturation point, a clear that collides with a hit, and a high glitch that breaks an interval. The ten-tick free window is driven with sparse ticks, so the 10th and 11th tick boundaries and the same-cycle drop on a low line are each observed directly.

// File: rtl/smb_tmo_pkg.sv
// Package: shared constants and types for the bus timeout monitor.
// Assumes nothing beyond IEEE 1800-2017 packages.
package smb_tmo_pkg;

    // Default number of clock-source ticks that must be exceeded for bus-free.
    localparam int unsigned FREE_TICKS_DEF = 10;

    // Default width of the programmable low-timeout limit.
    localparam int unsigned LIMIT_W_DEF = 24;

    // Snapshot of both bus lines.
    typedef struct packed {
        logic scl;
        logic sda;
    } bus_lines_t;

endpackage

// File: rtl/smb_low_timer.sv
// Module: clock-low timeout timer.
// Counts system clocks while the clock line is low, reloads while it is high,
// saturates at the limit and raises a sticky flag once per interval.
// Assumes scl is synchronized and the limit is held stable while counting.
module smb_low_timer #(
    parameter int unsigned CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             scl,
    input  logic [CNT_W-1:0] limit,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt,
    output logic             flag
);

    logic [CNT_W-1:0] cnt_q;
    logic             flag_q;
    logic             below;
    logic             hit;

    // Purpose: detect that this edge completes the limit-th low sample.
    always_comb begin
        below = (cnt_q < limit);
        hit   = en && !scl && below && ((cnt_q + 1'b1) == limit);
    end

    // Purpose: reload while high or disabled, count while low, saturate at limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en || scl) begin
            cnt_q <= '0;
        end else if (below) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Purpose: sticky flag, set on hit (priority over clear), cleared by pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (!en) begin
            flag_q <= 1'b0;
        end else if (hit) begin
            flag_q <= 1'b1;
        end else if (clr) begin
            flag_q <= 1'b0;
        end
    end

    // Purpose: force the flag inactive in the same cycle the enable drops.
    assign flag = flag_q & en;
    assign cnt  = cnt_q;

endmodule

// File: rtl/smb_free_detect.sv
// Module: bus-free detector.
// Counts clock-source ticks while both lines are high; declares the bus free
// once more than TICKS ticks have been seen. Any low line restarts the count.
// Assumes src_tick is a single-cycle pulse in the system clock domain.
module smb_free_detect
    import smb_tmo_pkg::*;
#(
    parameter int unsigned TICKS = FREE_TICKS_DEF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  bus_lines_t lines,
    input  logic       tick,
    output logic       free
);

    localparam int unsigned CW = $clog2(TICKS + 2);
    localparam logic [CW-1:0] LAST = CW'(TICKS);

    logic [CW-1:0] tick_cnt;
    logic          idle;

    // Purpose: both lines high means the bus could be idle.
    assign idle = lines.scl & lines.sda;

    // Purpose: count ticks while idle, saturating one past the threshold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_cnt <= '0;
        end else if (!en || !idle) begin
            tick_cnt <= '0;
        end else if (tick && (tick_cnt <= LAST)) begin
            tick_cnt <= tick_cnt + 1'b1;
        end
    end

    // Purpose: level output that drops in the same cycle a line goes low.
    assign free = en && idle && (tick_cnt > LAST);

endmodule

// File: rtl/smbus_timeout_mon.sv
// Module: top of the bus timeout monitor.
// Joins the clock-low timer and the bus-free detector. Recovery is external.
// Assumes scl_in and sda_in are already synchronized to clk.
module smbus_timeout_mon
    import smb_tmo_pkg::*;
#(
    parameter int unsigned LIMIT_W    = LIMIT_W_DEF,
    parameter int unsigned FREE_TICKS = FREE_TICKS_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_in,
    input  logic               sda_in,
    input  logic               src_tick,
    input  logic               low_tmo_en,
    input  logic               free_tmo_en,
    input  logic [LIMIT_W-1:0] low_limit,
    input  logic               low_tmo_clr,
    output logic               low_tmo_flag,
    output logic               bus_free
);

    bus_lines_t         lines;
    logic [LIMIT_W-1:0] low_cnt;

    // Purpose: bundle the two line levels.
    assign lines = '{scl: scl_in, sda: sda_in};

    smb_low_timer #(.CNT_W(LIMIT_W)) u_low (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (low_tmo_en),
        .scl   (scl_in),
        .limit (low_limit),
        .clr   (low_tmo_clr),
        .cnt   (low_cnt),
        .flag  (low_tmo_flag)
    );

    smb_free_detect #(.TICKS(FREE_TICKS)) u_free (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (free_tmo_en),
        .lines (lines),
        .tick  (src_tick),
        .free  (bus_free)
    );

endmodule

// File: rtl/smb_tmo_checker.sv
// Module: assertion checker for the bus timeout monitor, bound to the top.
module smb_tmo_checker #(
    parameter int unsigned LIMIT_W = 24
) (
    input logic               clk,
    input logic               rst_n,
    input logic               scl_in,
    input logic               sda_in,
    input logic               low_tmo_en,
    input logic               free_tmo_en,
    input logic [LIMIT_W-1:0] low_limit,
    input logic               low_tmo_clr,
    input logic [LIMIT_W-1:0] low_cnt,
    input logic               low_tmo_flag,
    input logic               bus_free
);

    p_reload_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        scl_in |=> (low_cnt == '0));

    p_count_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (low_tmo_en && !scl_in && (low_cnt < low_limit)) |=> (low_cnt == $past(low_cnt) + 1'b1));

    p_flag_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(low_tmo_flag) |-> (($past(low_cnt) + 1'b1) == $past(low_limit)));

    p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (low_tmo_flag && !low_tmo_clr) |=> (low_tmo_flag || !low_tmo_en));

    p_zero_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(low_tmo_flag) |-> ($past(low_limit) != '0));

    p_free_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_in || !sda_in) |-> !bus_free);

    p_low_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !low_tmo_en |-> !low_tmo_flag);

    p_free_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !free_tmo_en |-> !bus_free);

endmodule

bind smbus_timeout_mon smb_tmo_checker #(.LIMIT_W(LIMIT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_in       (scl_in),
    .sda_in       (sda_in),
    .low_tmo_en   (low_tmo_en),
    .free_tmo_en  (free_tmo_en),
    .low_limit    (low_limit),
    .low_tmo_clr  (low_tmo_clr),
    .low_cnt      (low_cnt),
    .low_tmo_flag (low_tmo_flag),
    .bus_free     (bus_free)
);

// File: tb/test_smbus_timeout_mon.sv
module test_smbus_timeout_mon;

    localparam int LW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          scl = 1'b1, sda = 1'b1, tick = 1'b0;
    logic          len = 1'b0, fen = 1'b0, clr = 1'b0;
    logic [LW-1:0] lim = '0;
    logic          flag, free;

    int n_cmp = 0, n_bad = 0, cycles = 0;
    string cur_req = "reset";
    bit done = 0;

    // Reference model state
    int  m_lc = 0, m_fc = 0;
    bit  m_flag = 0;

    always #2.5 clk = ~clk;

    smbus_timeout_mon #(.LIMIT_W(LW), .FREE_TICKS(10)) i_smbus_timeout_mon (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda), .src_tick(tick),
        .low_tmo_en(len), .free_tmo_en(fen), .low_limit(lim), .low_tmo_clr(clr),
        .low_tmo_flag(flag), .bus_free(free)
    );

    // Behavioural reference, updated from the inputs sampled at each edge.
    always @(posedge clk) begin
        bit hit;
        if (!rst_n) begin
            m_lc = 0; m_flag = 0; m_fc = 0;
        end else begin
            hit = 0;
            if (!len) begin
                m_lc = 0; m_flag = 0;
            end else begin
                if (scl) m_lc = 0;
                else begin
                    if (m_lc < int'(lim)) begin
                        if (m_lc + 1 == int'(lim)) hit = 1;
                        m_lc++;
                    end
                end
                if (hit) m_flag = 1;
                else if (clr) m_flag = 0;
            end
            if (!fen || !scl || !sda) m_fc = 0;
            else if (tick && m_fc < 11) m_fc++;
        end
    end

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin
        bit ef, eb;
        if (!done) begin
            ef = rst_n ? (m_flag && len) : 1'b0;
            eb = rst_n ? (fen && scl && sda && m_fc >= 11) : 1'b0;
            if (rst_n || cycles > 0) begin
                n_cmp++;
                if (flag !== ef || free !== eb) begin
                    n_bad++;
                    $display("FAIL %s: flag=%b free=%b expected flag=%b free=%b at %0t",
                             cur_req, flag, free, ef, eb, $time);
                end
            end
        end
    end

    task automatic chk(input string req, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic hold(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic pulse_clr();
        clr = 1; hold(1); clr = 0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1; hold(1); tick = 0; hold(2);
        end
    endtask

    task automatic summary();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
        end
    end

    initial begin
        hold(3);
        chk("reset flag", flag, 1'b0);
        chk("reset free", free, 1'b0);
        rst_n = 1; hold(1);

        // R1: broken intervals never flag
        cur_req = "R1"; len = 1; lim = 8'd6;
        scl = 0; hold(5); scl = 1; hold(1); scl = 0; hold(5);
        chk("R1 glitch", flag, 1'b0);
        scl = 1; hold(2);

        // R2: exact rising cycle
        cur_req = "R2"; scl = 0; hold(5);
        chk("R2 before limit", flag, 1'b0);
        hold(1);
        chk("R2 at limit", flag, 1'b1);

        // R3: sticky then clear
        cur_req = "R3"; scl = 1; hold(4);
        chk("R3 sticky", flag, 1'b1);
        pulse_clr();
        chk("R3 cleared", flag, 1'b0);
        // clear colliding with hit
        scl = 0; hold(5); clr = 1; hold(1); clr = 0;
        chk("R3 set wins", flag, 1'b1);

        // R4: clear while still low, no re-set
        cur_req = "R4"; hold(3); pulse_clr(); hold(20);
        chk("R4 no reflag", flag, 1'b0);
        scl = 1; hold(1); scl = 0; hold(6);
        chk("R4 fresh interval", flag, 1'b1);
        scl = 1; pulse_clr();

        // R5: limit zero
        cur_req = "R5"; lim = 8'd0; scl = 0; hold(30);
        chk("R5 zero limit", flag, 1'b0);
        scl = 1; hold(1);

        // limit 1 and 255 corners (R2)
        cur_req = "R2"; lim = 8'd1; scl = 0; hold(1);
        chk("R2 limit one", flag, 1'b1);
        scl = 1; pulse_clr(); lim = 8'd255; scl = 0; hold(254);
        chk("R2 limit 255 early", flag, 1'b0);
        hold(1);
        chk("R2 limit 255", flag, 1'b1);

        // R8: disable drops flag, re-enable needs a full interval
        cur_req = "R8"; len = 0; #0.5;
        chk("R8 same cycle", flag, 1'b0);
        hold(2); lim = 8'd6; len = 1; hold(5);
        chk("R8 restart", flag, 1'b0);
        hold(1);
        chk("R8 full interval", flag, 1'b1);
        scl = 1; pulse_clr();

        // R6: bus free after 11 ticks
        cur_req = "R6"; fen = 1; scl = 1; sda = 1; hold(2);
        ticks(10);
        chk("R6 ten ticks", free, 1'b0);
        ticks(1);
        chk("R6 eleven ticks", free, 1'b1);
        ticks(3);

        // R7: low line drops output and restarts
        cur_req = "R7"; sda = 0; #0.5;
        chk("R7 same cycle", free, 1'b0);
        hold(1); sda = 1; ticks(10);
        chk("R7 restart", free, 1'b0);
        ticks(1);
        chk("R7 refree", free, 1'b1);
        scl = 0; #0.5;
        chk("R7 scl low", free, 1'b0);
        hold(1); scl = 1; ticks(11);

        // R9: free disable
        cur_req = "R9"; fen = 0; #0.5;
        chk("R9 gated", free, 1'b0);
        hold(1); ticks(5); fen = 1; ticks(10);
        chk("R9 restart", free, 1'b0);
        ticks(1);
        chk("R9 refree", free, 1'b1);

        hold(3);
        summary();
    end

endmodule